// File: doc/BRIEF.md
# MCU Power Mode Controller

This block sequences a small microcontroller core between three power levels: running, idle and power-down. Software puts the core to sleep by writing the power-control register. In idle only the CPU clock stops; peripherals, timers and interrupt logic keep their clock. In power-down every clock and the oscillator stop. The block drives the clock enables, the oscillator enable and the levels of the two external bus strobes (address latch and program-store enable). The two strobes pass through from the core while it runs.

The two sleep levels have different wake sources. Idle ends when the interrupt controller starts servicing any enabled interrupt. Power-down ignores interrupt starts. It ends only when the level-sensitive external interrupt pin (active low, with its enable set) is held low. The low level restarts the oscillator. The pin must stay low for a parameterised number of oscillator cycles (default 1024). The core resumes only once the pin returns high. If the pin rises early, the oscillator is stopped again and the count starts over. A hardware reset returns the core to running from any state. Each completed wake raises a one-cycle pulse toward the interrupt controller. The mode bits read back as the current state.

States: RUN, IDLE, PDOWN (oscillator stopped), OSC_WAIT (oscillator restarting, counting low cycles), WAKE_HOLD (count complete, waiting for the pin to rise). Transitions: RUN→IDLE on a write with only bit 0 set. RUN→PDOWN on a write with bit 1 set. IDLE→RUN on an interrupt start. PDOWN→OSC_WAIT on an enabled low pin. OSC_WAIT→PDOWN if the pin is high at an edge. OSC_WAIT→WAKE_HOLD after the last counted low edge. WAKE_HOLD→RUN when the pin is high. Any state→RUN on reset.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the block is in RUN. `reg_rdata` is 0x00 and all three enables are 1. `ale_lvl`/`psen_lvl` follow `cpu_ale`/`cpu_psen`, and `wake_pulse` is 0.
- R2: In RUN, a write whose bits [1:0] are 01 (value 0x01) enters idle at the next edge. The CPU clock enable goes to 0, the peripheral and oscillator enables stay at 1, both strobes are driven high, and `reg_rdata` reads 0x01.
- R3: In RUN, a write with bit 1 set (value 0x02) enters power-down at the next edge. All three enables go to 0, both strobes are driven low, and `reg_rdata` reads 0x02.
- R4: A write with both bits set (0x03) enters power-down, and `reg_rdata` reads 0x02.
- R5: In idle, `irq_start` returns the block to RUN at the next edge and clears bit 0. A low external pin without `irq_start` leaves idle unchanged.
- R6: In power-down, `irq_start` has no effect, and a low pin has no effect while `ext_en` is 0.
- R7: In power-down with `ext_en` at 1, a low pin sampled at an edge raises `osc_en` from that edge. CPU and peripheral clocks stay off, the strobes stay low and `reg_rdata` stays 0x02.
- R8: After the restart, the pin must be sampled low on `OSC_WAIT_CYCLES` consecutive edges. If it is high at an earlier edge, the block returns to power-down with `osc_en` 0, and the next restart counts again from zero.
- R9: Once the count completes, the core stays stopped while the pin is low. At the first edge with the pin high the block enters RUN and `reg_rdata` reads 0x00.
- R10: A hardware reset in idle or power-down returns the block to RUN with both mode bits clear.
- R11: Writes while not in RUN are ignored, and a write with bits [1:0] = 00 in RUN has no effect.
- R12: `wake_pulse` is high for exactly one cycle after an idle or power-down exit, together with the return of the CPU clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock (modelled as free running) |
| rst_n | input | 1 | Hardware reset, asynchronous, active low |
| reg_wr | input | 1 | Power-control register write strobe |
| reg_wdata | input | 8 | Write data; bit 0 idle request, bit 1 power-down request |
| reg_rdata | output | 8 | Read-back; bit 0 idle active, bit 1 power-down active |
| irq_start | input | 1 | Interrupt service entry from the interrupt controller |
| ext_pin | input | 1 | Level-sensitive external interrupt pin, active low |
| ext_en | input | 1 | Enable of the level-sensitive external interrupt |
| cpu_ale | input | 1 | Address latch strobe from the core |
| cpu_psen | input | 1 | Program-store enable from the core |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Peripheral and interrupt logic clock enable |
| osc_en | output | 1 | Oscillator enable |
| ale_lvl | output | 1 | Address latch strobe as driven to the pin |
| psen_lvl | output | 1 | Program-store enable as driven to the pin |
| wake_pulse | output | 1 | One-cycle wake indication to the interrupt controller |

## Verification
The bench checks the oscillator-restart window at both of its edges. A pin that rises one edge short of the count must drop the oscillator again. A design that counts one cycle too few would wake there instead. A second short attempt right after the first catches a counter that is not cleared between attempts, because such a design would add the old count to the new one and wake early. It also checks that power-down ignores interrupt starts and a disabled pin, since a design that shares idle's wake sources would restart the oscillator there. Other checks cover a combined write that must give power-down rather than idle, and a wake that must wait for the pin to rise rather than resuming at the end of the count.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
    typedef enum logic [2:0] {
        ST_RUN       = 3'd0,
        ST_IDLE      = 3'd1,
        ST_PDOWN     = 3'd2,
        ST_OSC_WAIT  = 3'd3,
        ST_WAKE_HOLD = 3'd4
    } pmc_state_e;
endpackage

// File: rtl/pmc_restart_cnt.sv
module pmc_restart_cnt #(
    parameter int unsigned CYCLES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic done
);
    localparam int unsigned CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_q;

    assign done = inc && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr || done) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
    import pmc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic [1:0] req_bits,
    input  logic       irq_start,
    input  logic       ext_pin,
    input  logic       ext_en,
    input  logic       cnt_done,
    output pmc_state_e state_q,
    output logic       wake_q,
    output logic       cnt_inc,
    output logic       cnt_clr
);
    pmc_state_e state_d;
    logic       wake_d;

    always_comb begin
        state_d = state_q;
        wake_d  = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (reg_wr && req_bits[1]) begin
                    state_d = ST_PDOWN;
                end else if (reg_wr && req_bits[0]) begin
                    state_d = ST_IDLE;
                end
            end
            ST_IDLE: begin
                if (irq_start) begin
                    state_d = ST_RUN;
                    wake_d  = 1'b1;
                end
            end
            ST_PDOWN: begin
                if (ext_en && !ext_pin) begin
                    state_d = ST_OSC_WAIT;
                end
            end
            ST_OSC_WAIT: begin
                if (ext_pin) begin
                    state_d = ST_PDOWN;
                end else if (cnt_done) begin
                    state_d = ST_WAKE_HOLD;
                end
            end
            ST_WAKE_HOLD: begin
                if (ext_pin) begin
                    state_d = ST_RUN;
                    wake_d  = 1'b1;
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    assign cnt_inc = (state_q == ST_OSC_WAIT) && !ext_pin;
    assign cnt_clr = (state_q != ST_OSC_WAIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            wake_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            wake_q  <= wake_d;
        end
    end
endmodule

// File: rtl/pmc_out_decode.sv
module pmc_out_decode
    import pmc_pkg::*;
(
    input  pmc_state_e state,
    input  logic       cpu_ale,
    input  logic       cpu_psen,
    output logic       cpu_clk_en,
    output logic       periph_clk_en,
    output logic       osc_en,
    output logic       ale_lvl,
    output logic       psen_lvl,
    output logic [1:0] mode_bits
);
    always_comb begin
        cpu_clk_en    = 1'b0;
        periph_clk_en = 1'b0;
        osc_en        = 1'b0;
        ale_lvl       = 1'b0;
        psen_lvl      = 1'b0;
        mode_bits     = 2'b10;
        unique case (state)
            ST_RUN: begin
                cpu_clk_en    = 1'b1;
                periph_clk_en = 1'b1;
                osc_en        = 1'b1;
                ale_lvl       = cpu_ale;
                psen_lvl      = cpu_psen;
                mode_bits     = 2'b00;
            end
            ST_IDLE: begin
                periph_clk_en = 1'b1;
                osc_en        = 1'b1;
                ale_lvl       = 1'b1;
                psen_lvl      = 1'b1;
                mode_bits     = 2'b01;
            end
            ST_PDOWN: begin
                osc_en = 1'b0;
            end
            ST_OSC_WAIT, ST_WAKE_HOLD: begin
                osc_en = 1'b1;
            end
            default: begin
                osc_en = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int unsigned OSC_WAIT_CYCLES = 1024,
    parameter int unsigned REG_W           = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             irq_start,
    input  logic             ext_pin,
    input  logic             ext_en,
    input  logic             cpu_ale,
    input  logic             cpu_psen,
    output logic             cpu_clk_en,
    output logic             periph_clk_en,
    output logic             osc_en,
    output logic             ale_lvl,
    output logic             psen_lvl,
    output logic             wake_pulse
);
    pmc_state_e state;
    logic       cnt_inc;
    logic       cnt_clr;
    logic       cnt_done;
    logic [1:0] mode_bits;

    pmc_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .req_bits  (reg_wdata[1:0]),
        .irq_start (irq_start),
        .ext_pin   (ext_pin),
        .ext_en    (ext_en),
        .cnt_done  (cnt_done),
        .state_q   (state),
        .wake_q    (wake_pulse),
        .cnt_inc   (cnt_inc),
        .cnt_clr   (cnt_clr)
    );

    pmc_restart_cnt #(
        .CYCLES (OSC_WAIT_CYCLES)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .done  (cnt_done)
    );

    pmc_out_decode u_dec (
        .state         (state),
        .cpu_ale       (cpu_ale),
        .cpu_psen      (cpu_psen),
        .cpu_clk_en    (cpu_clk_en),
        .periph_clk_en (periph_clk_en),
        .osc_en        (osc_en),
        .ale_lvl       (ale_lvl),
        .psen_lvl      (psen_lvl),
        .mode_bits     (mode_bits)
    );

    assign reg_rdata = {{(REG_W-2){1'b0}}, mode_bits};
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk #(
    parameter int unsigned REG_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [REG_W-1:0] reg_wdata,
    input logic [REG_W-1:0] reg_rdata,
    input logic             irq_start,
    input logic             ext_pin,
    input logic             ext_en,
    input logic             cpu_clk_en,
    input logic             periph_clk_en,
    input logic             osc_en,
    input logic             ale_lvl,
    input logic             psen_lvl,
    input logic             wake_pulse
);
    p_idle_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_clk_en && reg_wr && reg_wdata[1:0] == 2'b01)
        |=> (reg_rdata[1:0] == 2'b01 && !cpu_clk_en && periph_clk_en && osc_en));

    p_pd_strobes_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[1] |-> (!ale_lvl && !psen_lvl && !cpu_clk_en && !periph_clk_en));

    p_single_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(reg_rdata[1:0]) <= 1);

    p_idle_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[0] && irq_start)
        |=> (cpu_clk_en && wake_pulse && reg_rdata[1:0] == 2'b00));

    p_pd_ignores_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[1] && !osc_en && !(ext_en && !ext_pin)) |=> !osc_en);

    p_osc_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(osc_en) |-> (reg_rdata[1] && $past(ext_en) && !$past(ext_pin)));

    p_wake_with_clk_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> (cpu_clk_en && reg_rdata[1:0] == 2'b00));

    p_wake_one_cycle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse);
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(.REG_W(REG_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_wr        (reg_wr),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .irq_start     (irq_start),
    .ext_pin       (ext_pin),
    .ext_en        (ext_en),
    .cpu_clk_en    (cpu_clk_en),
    .periph_clk_en (periph_clk_en),
    .osc_en        (osc_en),
    .ale_lvl       (ale_lvl),
    .psen_lvl      (psen_lvl),
    .wake_pulse    (wake_pulse)
);

// File: tb/pwr_mode_ctrl_bench.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_bench;
    localparam int unsigned N      = 1024;
    localparam int unsigned NVEC   = 12;
    localparam int unsigned WD_CYC = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq_start = 1'b0;
    logic       ext_pin = 1'b1;
    logic       ext_en = 1'b0;
    logic       cpu_ale = 1'b0;
    logic       cpu_psen = 1'b1;
    logic       cpu_clk_en, periph_clk_en, osc_en, ale_lvl, psen_lvl, wake_pulse;

    int n_run  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    pwr_mode_ctrl u_pwr_mode_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_wr        (reg_wr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .irq_start     (irq_start),
        .ext_pin       (ext_pin),
        .ext_en        (ext_en),
        .cpu_ale       (cpu_ale),
        .cpu_psen      (cpu_psen),
        .cpu_clk_en    (cpu_clk_en),
        .periph_clk_en (periph_clk_en),
        .osc_en        (osc_en),
        .ale_lvl       (ale_lvl),
        .psen_lvl      (psen_lvl),
        .wake_pulse    (wake_pulse)
    );

    // Observed bundle: {rd[1], rd[0], cpu, periph, osc, ale, psen, wake}
    function automatic logic [7:0] obs();
        return {reg_rdata[1:0], cpu_clk_en, periph_clk_en, osc_en,
                ale_lvl, psen_lvl, wake_pulse};
    endfunction

    localparam logic [7:0] O_RUN   = 8'b00_11101_0;
    localparam logic [7:0] O_WAKE  = 8'b00_11101_1;
    localparam logic [7:0] O_IDLE  = 8'b01_01111_0;
    localparam logic [7:0] O_PD    = 8'b10_00000_0;
    localparam logic [7:0] O_OSCON = 8'b10_00100_0;

    // {wr, wd[1:0], irq, pin, en, expected bundle[7:0]}
    localparam logic [13:0] VEC [NVEC] = '{
        {1'b0, 2'b00, 1'b0, 1'b1, 1'b0, O_RUN},  // R1 quiet run
        {1'b1, 2'b00, 1'b0, 1'b1, 1'b0, O_RUN},  // R11 zero write
        {1'b1, 2'b01, 1'b0, 1'b1, 1'b0, O_IDLE}, // R2 idle entry
        {1'b1, 2'b10, 1'b0, 1'b1, 1'b0, O_IDLE}, // R11 write in idle
        {1'b0, 2'b00, 1'b0, 1'b0, 1'b1, O_IDLE}, // R5 pin alone in idle
        {1'b0, 2'b00, 1'b1, 1'b1, 1'b0, O_WAKE}, // R5 irq exits idle
        {1'b0, 2'b00, 1'b0, 1'b1, 1'b0, O_RUN},  // R12 pulse ends
        {1'b1, 2'b11, 1'b0, 1'b1, 1'b0, O_PD},   // R4 both bits
        {1'b0, 2'b00, 1'b1, 1'b1, 1'b0, O_PD},   // R6 irq ignored
        {1'b0, 2'b00, 1'b0, 1'b0, 1'b0, O_PD},   // R6 disabled pin ignored
        {1'b1, 2'b01, 1'b0, 1'b1, 1'b0, O_PD},   // R11 write in power-down
        {1'b0, 2'b00, 1'b0, 1'b1, 1'b1, O_PD}    // R6 high pin no wake
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic drive(input logic wr, input logic [1:0] wd, input logic irq,
                         input logic pin, input logic en);
        @(negedge clk);
        reg_wr    = wr;
        reg_wdata = {6'b0, wd};
        irq_start = irq;
        ext_pin   = pin;
        ext_en    = en;
    endtask

    task automatic edge_then_sample();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (WD_CYC) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 reset state", obs(), O_RUN);
        check("R1 strobe pass-through", {ale_lvl, psen_lvl}, 8'b0000_0001);

        for (int i = 0; i < NVEC; i++) begin
            logic [13:0] v;
            v = VEC[i];
            drive(v[13], v[12:11], v[10], v[9], v[8]);
            edge_then_sample();
            check($sformatf("table vector %0d", i), obs(), v[7:0]);
        end

        // R10: reset out of power-down
        do_reset();
        #1;
        check("R10 reset from power-down", obs(), O_RUN);

        // R3: plain power-down entry
        drive(1'b1, 2'b10, 1'b0, 1'b1, 1'b1);
        edge_then_sample();
        check("R3 power-down entry", obs(), O_PD);

        // R7: enabled low pin restarts oscillator
        drive(1'b0, 2'b00, 1'b0, 1'b0, 1'b1);
        edge_then_sample();
        check("R7 oscillator restart", obs(), O_OSCON);

        // R8: rise after N-1 counted lows -> back to power-down
        repeat (N - 1) @(posedge clk);
        drive(1'b0, 2'b00, 1'b0, 1'b1, 1'b1);
        edge_then_sample();
        check("R8 early rise returns to power-down", obs(), O_PD);

        // R8: second short attempt must also fail (counter cleared)
        drive(1'b0, 2'b00, 1'b0, 1'b0, 1'b1);
        repeat (N) @(posedge clk);
        drive(1'b0, 2'b00, 1'b0, 1'b1, 1'b1);
        edge_then_sample();
        check("R8 count restarts from zero", obs(), O_PD);

        // R9: full hold, then wait for rise
        drive(1'b0, 2'b00, 1'b0, 1'b0, 1'b1);
        repeat (N + 4) @(posedge clk);
        #1;
        check("R9 core held while pin low", obs(), O_OSCON);
        drive(1'b0, 2'b00, 1'b1, 1'b1, 1'b1);
        edge_then_sample();
        check("R9 wake on pin rise", obs(), O_WAKE);
        drive(1'b0, 2'b00, 1'b0, 1'b1, 1'b0);
        edge_then_sample();
        check("R12 wake pulse single cycle", obs(), O_RUN);

        // R10: reset out of idle
        drive(1'b1, 2'b01, 1'b0, 1'b1, 1'b0);
        edge_then_sample();
        check("R2 idle before reset", obs(), O_IDLE);
        reg_wr = 1'b0;
        do_reset();
        #1;
        check("R10 reset from idle", obs(), O_RUN);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule